// File: doc/BRIEF.md
# Triggered Pulse Burst Generator

This block emits a finite train of square pulses on one output, started by a single-cycle trigger. The pulse rate comes from the system clock: a prescaler divides it by a power of two picked by a divide-select input, and each pulse is one prescaled period high followed by one prescaled period low. The pulse period is therefore `2^x * 2` clock cycles, where `x` is the divide select. The number of pulses in one burst, `y`, comes from a burst-length input.

A busy flag is high while a burst runs, so the controlling logic can poll it before it asks for another burst. The divide select and the burst length are captured when a burst is accepted, so changing them mid-burst has no effect. A force-high input overrides the output and lets the pin serve as a plain static output. An enable input gates the whole circuit: when it is low the output is low, triggers are refused and any running burst is cut short.

Top module: `burst_pulse_gen`

## Requirements
- R1: After reset, `busy` is 0 and `pulse_out` is 0 while `force_high` is 0.
- R2: During a burst accepted with divide select `x`, `pulse_out` is high for `2^x` cycles and then low for `2^x` cycles, starting in the cycle right after the accepting clock edge.
- R3: A burst accepted with burst length `y` (1 to 2^LEN_W-1) produces exactly `y` high periods; `pulse_out` is low from then on while idle and `force_high` is 0.
- R4: `busy` reads 1 from the cycle after the accepting edge for `y * 2^(x+1)` cycles and reads 0 afterwards.
- R5: A `start` that is high while `busy` is 1 is ignored: the running burst keeps its timing and no second burst follows.
- R6: A `start` with `burst_len` equal to 0 is ignored: `busy` stays 0 and no pulse is produced.
- R7: Changes of `div_sel` or `burst_len` while `busy` is 1 do not change the running burst.
- R8: While `force_high` is 1, `pulse_out` is 1; the burst sequence and `busy` continue unchanged underneath.
- R9: While `enable` is 0, `pulse_out` equals `force_high`, `start` is ignored, and a running burst is aborted so that `busy` is 0 one cycle after `enable` is seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Gates the divider and burst logic |
| start | input | 1 | Burst trigger, sampled on each rising edge |
| force_high | input | 1 | Drives `pulse_out` to 1 regardless of the burst |
| div_sel | input | DIV_W | Prescale exponent `x`; divide by `2^x` |
| burst_len | input | LEN_W | Pulse count `y` of the next burst |
| busy | output | 1 | High while a burst is in progress |
| pulse_out | output | 1 | Burst output |

## Verification
The bench sweeps divide selects and burst lengths and compares every cycle of `pulse_out` and `busy` with a period computed from `x` and `y`. A divider off by one would stretch or shrink each half-period, and a counter compared at the wrong moment would add or drop the final pulse or leave `busy` high one cycle too long. The extremes get their own runs: length 1, the largest length, the slowest divide and the unit divide. A second trigger and new settings are applied mid-burst to catch a design that restarts or re-reads its settings. A zero length, a forced output and an enable drop mid-burst are also checked, to catch a design that hangs in busy, lets the burst show through the override, or leaves a stale pulse after disable.

// File: rtl/bpg_pkg.sv
// Package: shared types of the burst pulse generator.
// Assumes: nothing beyond standard SystemVerilog.
package bpg_pkg;
    // Phase of the output square wave during a burst.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_t;
endpackage

// File: rtl/bpg_divider.sv
// Module: bpg_divider
// Counts clock cycles and raises `tick` once every 2^sel cycles while `run`
// is high. The count is forced to zero while `run` is low or `clear` is high,
// so the first tick after a start lands exactly 2^sel cycles later.
// Assumes: `sel` is stable while `run` is high (the sequencer latches it).
module bpg_divider #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1 > 0 ? (1 << DIV_W) - 1 : 1;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] limit;

    // Build the terminal count 2^sel - 1 as a run of ones.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            limit[i] = (i < int'(sel));
        end
    end

    // A tick marks the last cycle of one prescaled period.
    assign tick = run && !clear && (count == limit);

    // Advance the prescale counter, wrapping at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clear || tick) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/bpg_sequencer.sv
// Module: bpg_sequencer
// Accepts a burst request, latches its settings, and walks the high/low
// phases of each pulse on every divider tick until the requested number of
// pulses is complete. Requests during a burst, requests with a zero length,
// and requests while disabled are refused. Dropping `enable` aborts a burst.
// Assumes: `tick` comes from a divider that is held cleared while idle.
module bpg_sequencer
    import bpg_pkg::*;
#(
    parameter int DIV_W = 3,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [LEN_W-1:0] burst_len,
    input  logic             tick,
    output logic [DIV_W-1:0] sel_q,
    output logic             accept,
    output logic             running,
    output logic             wave
);
    phase_t           phase;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] done_cnt;
    logic             last_pulse;

    // A request is taken only when idle, enabled and with a nonzero length.
    assign accept     = enable && start && (phase == PH_IDLE) && (burst_len != '0);
    assign last_pulse = (done_cnt + 1'b1) == len_q;
    assign running    = (phase != PH_IDLE);
    assign wave       = (phase == PH_HIGH);

    // Phase state machine with burst abort on disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase <= PH_IDLE;
        end else if (accept) begin
            phase <= PH_HIGH;
        end else if (tick) begin
            case (phase)
                PH_HIGH: phase <= PH_LOW;
                PH_LOW:  phase <= last_pulse ? PH_IDLE : PH_HIGH;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Count completed pulses; cleared on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            done_cnt <= '0;
        end else if (accept) begin
            done_cnt <= '0;
        end else if (tick && phase == PH_LOW) begin
            done_cnt <= done_cnt + 1'b1;
        end
    end

    // Capture the burst settings at acceptance so later changes are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            sel_q <= '0;
        end else if (accept) begin
            len_q <= burst_len;
            sel_q <= div_sel;
        end
    end
endmodule

// File: rtl/burst_pulse_gen.sv
// Module: burst_pulse_gen (top)
// Triggered pulse burst generator: a power-of-two prescaler sets the pulse
// rate, a sequencer produces a programmed number of square pulses, and an
// output stage applies the enable gate and the force-high override.
// Assumes: `start` is a request sampled each edge; settings are taken at
// acceptance. Reset is synchronous and active low.
module burst_pulse_gen #(
    parameter int DIV_W = 3,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic             force_high,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [LEN_W-1:0] burst_len,
    output logic             busy,
    output logic             pulse_out
);
    logic [DIV_W-1:0] sel_q;
    logic             accept;
    logic             running;
    logic             wave;
    logic             tick;

    bpg_sequencer #(
        .DIV_W(DIV_W),
        .LEN_W(LEN_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .start    (start),
        .div_sel  (div_sel),
        .burst_len(burst_len),
        .tick     (tick),
        .sel_q    (sel_q),
        .accept   (accept),
        .running  (running),
        .wave     (wave)
    );

    bpg_divider #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (running),
        .clear(accept),
        .sel  (sel_q),
        .tick (tick)
    );

    // Output stage: override first, then the enable-gated burst wave.
    assign pulse_out = force_high || (enable && wave);
    assign busy      = running;
endmodule

// File: rtl/bpg_checker.sv
// Module: bpg_checker
// Temporal properties of burst_pulse_gen, attached with bind below.
// Assumes: the same clock and synchronous active-low reset as the top.
module bpg_checker #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             start,
    input logic             force_high,
    input logic [LEN_W-1:0] burst_len,
    input logic             busy,
    input logic             pulse_out
);
    // R4: an accepted request raises busy on the next cycle.
    p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start && !busy && burst_len != '0) |=> busy);

    // R3: when idle and not forced, the output is low.
    p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !force_high) |-> !pulse_out);

    // R8: the override always wins.
    p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force_high |-> pulse_out);

    // R9: disable aborts any burst on the next cycle.
    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy);

    // R6: a zero-length request does not start a burst.
    p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && burst_len == '0) |=> !busy);

    // R9: with enable low the output follows the override alone.
    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (pulse_out == force_high));
endmodule

bind burst_pulse_gen bpg_checker #(
    .LEN_W(LEN_W)
) u_bpg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .start     (start),
    .force_high(force_high),
    .burst_len (burst_len),
    .busy      (busy),
    .pulse_out (pulse_out)
);

// File: tb/tb_burst_pulse_gen.sv
// Bench for burst_pulse_gen: sweeps divide selects and burst lengths and
// compares every cycle against a period computed from x and y.
module tb_burst_pulse_gen;
    localparam int DIV_W = 3;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             start = 1'b0;
    logic             force_high = 1'b0;
    logic [DIV_W-1:0] div_sel = '0;
    logic [LEN_W-1:0] burst_len = '0;
    logic             busy;
    logic             pulse_out;

    int checks = 0;
    int errors = 0;

    burst_pulse_gen #(.DIV_W(DIV_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .force_high(force_high), .div_sel(div_sel), .burst_len(burst_len),
        .busy(busy), .pulse_out(pulse_out)
    );

    always #10 clk = ~clk;  // 50 MHz

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Issue a request at the next edge; returns at the negedge of cycle 0.
    task automatic fire(input int x, input int y);
        div_sel   = DIV_W'(x);
        burst_len = LEN_W'(y);
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    // Follow one burst cycle by cycle; optionally disturb it mid-way (R5, R7).
    task automatic run_burst(input int x, input int y, input bit disturb, input bit forced);
        int h = 1 << x;
        int p = 2 * h;
        int total = y * p;
        force_high = forced;
        fire(x, y);
        for (int k = 0; k < total + 3; k++) begin
            logic eb = (k < total);
            logic ew = forced ? 1'b1 : (eb && ((k % p) < h));
            chk(busy, eb, disturb ? "R5/R7" : "R4", "busy");
            chk(pulse_out, ew, forced ? "R8" : (disturb ? "R7" : "R2/R3"), "pulse_out");
            if (disturb && k == 1) begin
                start = 1'b1;
                div_sel = ~DIV_W'(x);
                burst_len = LEN_W'(y + 3);
            end else if (disturb && k == 2) begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        force_high = 1'b0;
        burst_len  = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy, 1'b0, "R1", "busy in reset");
        chk(pulse_out, 1'b0, "R1", "pulse_out in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy, 1'b0, "R1", "busy after reset");
        chk(pulse_out, 1'b0, "R1", "pulse_out after reset");
        enable = 1'b1;
        @(negedge clk);

        // R2 R3 R4: sweep of divide select and length
        for (int x = 0; x < 4; x++) begin
            for (int y = 1; y <= 4; y++) begin
                run_burst(x, y, 1'b0, 1'b0);
            end
        end
        // boundaries: slowest divide, longest burst
        run_burst(7, 1, 1'b0, 1'b0);
        run_burst(0, 255, 1'b0, 1'b0);

        // R5 R7: second request and new settings mid-burst
        run_burst(1, 3, 1'b1, 1'b0);
        run_burst(0, 2, 1'b1, 1'b0);

        // R8: forced output over a running burst
        run_burst(1, 2, 1'b0, 1'b1);

        // R6: zero length refused
        fire(2, 0);
        for (int k = 0; k < 6; k++) begin
            chk(busy, 1'b0, "R6", "busy with zero length");
            chk(pulse_out, 1'b0, "R6", "pulse_out with zero length");
            @(negedge clk);
        end

        // R9: abort on disable
        fire(2, 3);
        repeat (2) @(negedge clk);
        chk(pulse_out, 1'b1, "R9", "pulse_out before abort");
        enable = 1'b0;
        #1;
        chk(pulse_out, 1'b0, "R9", "pulse_out gated same cycle");
        @(negedge clk);
        chk(busy, 1'b0, "R9", "busy after abort");
        // R9: request while disabled ignored; override still passes
        fire(1, 2);
        for (int k = 0; k < 5; k++) begin
            chk(busy, 1'b0, "R9", "busy while disabled");
            chk(pulse_out, 1'b0, "R9", "pulse_out while disabled");
            @(negedge clk);
        end
        force_high = 1'b1;
        #1;
        chk(pulse_out, 1'b1, "R9", "override while disabled");
        force_high = 1'b0;
        enable = 1'b1;
        @(negedge clk);
        // fresh burst after abort starts cleanly
        run_burst(0, 1, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule